// File: doc/BRIEF.md
# Oversampled Serial Line Receiver

This block recovers 8-bit bytes from a single serial input line. The system clock runs at sixteen times the bit rate. A frame is ten bits long: a start bit, eight data bits sent least significant bit first, and a stop bit. The line polarity is inverted. The line rests low, the start bit is high and a good stop bit is low.

A controller hunts for a rising line and checks that the start bit is still high when a mid-bit strobe arrives. That strobe comes from a mod-16 bit timer, which is preloaded while idle. After the start bit, the controller steps through eight mid-bit samples and shifts each one into an 8-bit register from the top end. A down-counting bit counter tells the controller when the byte is complete. At the next strobe the controller checks the stop bit without storing it.

If the stop bit is good, the byte is copied to the output and a ready flag stays high for one bit time. If the stop bit is bad, the byte is dropped and the controller waits for the line to return low before it hunts again. A frame's start bit may begin no earlier than one idle bit time after the previous stop bit ends.

Top module: `ovs_line_rx`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to hunting, with `ready` low and `data_out` equal to 0.
- R2: The first high sample of the line while hunting counts as clock 0. A start bit is accepted only if the line is high on every sample from clock 0 through clock 10. A start bit that is high for exactly 10 clocks is rejected, and one that is high for 11 clocks is accepted.
- R3: A low sample at any clock from 1 to 10 after the first high sample aborts the frame and returns the block to hunting, with no `ready` pulse and no change to `data_out`.
- R4: Data bit n (n = 0..7) is the line value sampled at clock 27 + 16·n after clock 0, which is one mid-bit strobe every 16 clocks.
- R5: The first data bit received appears in `data_out[0]` and the last in `data_out[7]`, so the byte is received least significant bit first.
- R6: The stop bit is the line value at clock 154. It is checked directly and never enters the data byte.
- R7: When the stop bit is low, `data_out` takes the new byte and `ready` rises on the same edge. `ready` then stays high for exactly 16 clocks.
- R8: When the stop bit is high, no `ready` pulse occurs and `data_out` keeps its previous value.
- R9: After a high stop bit, the block ignores the line for as long as the line stays high. Only after one low sample does it hunt for the next start bit, and a following frame is then received normally.
- R10: `data_out` changes only on the edge where `ready` rises. Line activity while `ready` is high neither shortens the pulse nor starts a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at 16 times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Serial line: idles low, high start bit, low stop bit |
| data_out | output | 8 | Last byte received with a good stop bit |
| ready | output | 1 | High for 16 clocks after a good frame |

## Verification
Two things can coincide. The stop-bit acceptance raises `ready` and loads `data_out`, and in the clocks that follow the line may already show new activity, which the hunting logic could mistake for a start bit. The bench provokes this by pulsing the line high during the ready window and by sending frames with only one idle bit time between them. It judges the result by checking that the ready pulse is exactly 16 clocks long, that no extra frame is reported, and that the next frame's byte arrives intact. A behavioural model counts clocks from each start-bit edge and is compared with `ready` and `data_out` on every clock.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;

    // Controller states: hunt for start, qualify start, wait for strobe,
    // take a data bit, hold ready, recover after a bad stop bit.
    typedef enum logic [2:0] {
        ST_HUNT    = 3'd0,
        ST_START   = 3'd1,
        ST_WAIT    = 3'd2,
        ST_ACQ     = 3'd3,
        ST_READY   = 3'd4,
        ST_RECOVER = 3'd5
    } rx_state_e;

endpackage

// File: rtl/ovs_bit_timer.sv
module ovs_bit_timer #(
    parameter int unsigned OVERSAMPLE = 16,
    parameter int unsigned PRELOAD    = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic tick
);
    localparam int unsigned CW = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);
    localparam logic [CW-1:0] INIT = CW'(PRELOAD);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = INIT;
        end else if (tmr_q.cnt == LAST) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q.cnt <= INIT;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // Mid-bit strobe: the counter sits at its terminal value.
    assign tick = (tmr_q.cnt == LAST);

endmodule

// File: rtl/ovs_bit_counter.sv
module ovs_bit_counter #(
    parameter int unsigned DATA_BITS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic dec,
    output logic zero
);
    localparam int unsigned CW = $clog2(DATA_BITS + 1);
    localparam logic [CW-1:0] FULL = CW'(DATA_BITS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } bcnt_t;

    bcnt_t bcnt_d, bcnt_q;

    always_comb begin
        bcnt_d = bcnt_q;
        if (load) begin
            bcnt_d.cnt = FULL;
        end else if (dec && (bcnt_q.cnt != '0)) begin
            bcnt_d.cnt = bcnt_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt_q.cnt <= FULL;
        end else begin
            bcnt_q <= bcnt_d;
        end
    end

    assign zero = (bcnt_q.cnt == '0);

endmodule

// File: rtl/ovs_shift_reg.sv
module ovs_shift_reg #(
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift_en,
    input  logic                 din,
    input  logic                 capture,
    output logic [DATA_BITS-1:0] data_out
);
    typedef struct packed {
        logic [DATA_BITS-1:0] shreg;
        logic [DATA_BITS-1:0] hold;
    } sr_t;

    sr_t sr_d, sr_q;
    logic [DATA_BITS-1:0] shifted;

    // New bits enter at the top and move toward bit 0.
    generate
        if (DATA_BITS == 1) begin : g_single
            assign shifted = din;
        end else begin : g_multi
            assign shifted = {din, sr_q.shreg[DATA_BITS-1:1]};
        end
    endgenerate

    always_comb begin
        sr_d = sr_q;
        if (shift_en) begin
            sr_d.shreg = shifted;
        end
        if (capture) begin
            sr_d.hold = sr_q.shreg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign data_out = sr_q.hold;

endmodule

// File: rtl/ovs_rx_ctrl.sv
module ovs_rx_ctrl
    import ovs_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      line_in,
    input  logic      tick,
    input  logic      bits_zero,
    output logic      hunting,
    output logic      take_bit,
    output logic      capture,
    output logic      ready,
    output rx_state_e state_o
);
    typedef struct packed {
        rx_state_e st;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_HUNT: begin
                if (line_in) ctl_d.st = ST_START;
            end
            ST_START: begin
                if (!line_in)  ctl_d.st = ST_HUNT;
                else if (tick) ctl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (tick) begin
                    if (!bits_zero)   ctl_d.st = ST_ACQ;
                    else if (line_in) ctl_d.st = ST_RECOVER;
                    else              ctl_d.st = ST_READY;
                end
            end
            ST_ACQ: begin
                ctl_d.st = ST_WAIT;
            end
            ST_READY: begin
                if (tick) ctl_d.st = ST_HUNT;
            end
            ST_RECOVER: begin
                if (!line_in) ctl_d.st = ST_HUNT;
            end
            default: begin
                ctl_d.st = ST_HUNT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st <= ST_HUNT;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign hunting  = (ctl_q.st == ST_HUNT);
    assign take_bit = (ctl_q.st == ST_ACQ);
    assign capture  = (ctl_q.st == ST_WAIT) && tick && bits_zero && !line_in;
    assign ready    = (ctl_q.st == ST_READY);
    assign state_o  = ctl_q.st;

endmodule

// File: rtl/ovs_line_rx.sv
module ovs_line_rx #(
    parameter int unsigned OVERSAMPLE = 16,
    parameter int unsigned PRELOAD    = 6,
    parameter int unsigned DATA_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_in,
    output logic [DATA_BITS-1:0] data_out,
    output logic                 ready
);
    import ovs_rx_pkg::*;

    logic      mid_tick;
    logic      bits_zero;
    logic      hunting;
    logic      take_bit;
    logic      capture;
    rx_state_e st;

    ovs_rx_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .line_in   (line_in),
        .tick      (mid_tick),
        .bits_zero (bits_zero),
        .hunting   (hunting),
        .take_bit  (take_bit),
        .capture   (capture),
        .ready     (ready),
        .state_o   (st)
    );

    ovs_bit_timer #(
        .OVERSAMPLE (OVERSAMPLE),
        .PRELOAD    (PRELOAD)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (hunting),
        .tick (mid_tick)
    );

    ovs_bit_counter #(
        .DATA_BITS (DATA_BITS)
    ) u_bits (
        .clk  (clk),
        .rst  (rst),
        .load (hunting),
        .dec  (take_bit),
        .zero (bits_zero)
    );

    ovs_shift_reg #(
        .DATA_BITS (DATA_BITS)
    ) u_sreg (
        .clk      (clk),
        .rst      (rst),
        .shift_en (take_bit),
        .din      (line_in),
        .capture  (capture),
        .data_out (data_out)
    );

endmodule

// File: rtl/ovs_line_rx_chk.sv
module ovs_line_rx_chk
    import ovs_rx_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16,
    parameter int unsigned DATA_BITS  = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 line_in,
    input logic                 ready,
    input logic [DATA_BITS-1:0] data_out,
    input rx_state_e            state,
    input logic                 tick,
    input logic                 bits_zero
);
    localparam int unsigned RW = $clog2(OVERSAMPLE) + 2;
    localparam logic [RW-1:0] RLEN = RW'(OVERSAMPLE);

    logic          past_ok_q;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok_q <= 1'b0;
            run_q     <= '0;
        end else begin
            past_ok_q <= 1'b1;
            run_q     <= ready ? run_q + 1'b1 : '0;
        end
    end

    // R1: reset leaves the controller hunting with ready low
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!ready && state == ST_HUNT));

    // R3: a low sample while qualifying the start bit aborts the frame
    assert_glitch_abort_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && !line_in) |=> (state == ST_HUNT));

    // R4: a data bit is taken only while the bit counter is not exhausted
    assert_acq_count_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACQ) |-> !bits_zero);

    // R7: the ready pulse never runs past one bit time
    assert_ready_max_R7: assert property (@(posedge clk) disable iff (rst)
        ready |-> (run_q < RLEN));

    // R7: when the ready pulse ends it has lasted exactly one bit time
    assert_ready_len_R7: assert property (@(posedge clk) disable iff (rst)
        (!ready && run_q != '0) |-> (run_q == RLEN));

    // R8: a high stop bit leads to recovery with no ready
    assert_bad_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && tick && bits_zero && line_in)
            |=> (state == ST_RECOVER && !ready));

    // R9: recovery holds while the line stays high
    assert_recover_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECOVER && line_in) |=> (state == ST_RECOVER));

    // R10: the output byte moves only when ready rises
    assert_data_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (past_ok_q && !$rose(ready)) |-> $stable(data_out));

endmodule

bind ovs_line_rx ovs_line_rx_chk #(
    .OVERSAMPLE (OVERSAMPLE),
    .DATA_BITS  (DATA_BITS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .line_in   (line_in),
    .ready     (ready),
    .data_out  (data_out),
    .state     (st),
    .tick      (mid_tick),
    .bits_zero (bits_zero)
);

// File: tb/test_ovs_line_rx.sv
`timescale 1ns/100ps
module test_ovs_line_rx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_in = 1'b0;
    logic [7:0] data_out;
    logic       ready;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ovs_line_rx i_ovs_line_rx (
        .clk      (clk),
        .rst      (rst),
        .line_in  (line_in),
        .data_out (data_out),
        .ready    (ready)
    );

    // Reference model: counts clocks from the first high sample of a frame.
    int         m_mode = 0;   // 0 hunt, 1 in frame, 2 ready, 3 recovery
    int         m_k = 0;
    int         m_rcnt = 0;
    logic [7:0] m_acc = 8'h00;
    logic [7:0] m_data = 8'h00;
    logic       m_ready = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0;
            m_data = 8'h00;
            m_acc  = 8'h00;
        end else begin
            case (m_mode)
                0: if (line_in) begin m_mode = 1; m_k = 0; end
                1: begin
                    m_k++;
                    if (m_k <= 10) begin
                        if (!line_in) m_mode = 0;            // R2 R3
                    end else if (m_k >= 27 && m_k <= 139 && (m_k - 27) % 16 == 0) begin
                        m_acc = {line_in, m_acc[7:1]};       // R4 R5
                    end else if (m_k == 154) begin           // R6
                        if (!line_in) begin
                            m_mode = 2; m_rcnt = 0; m_data = m_acc;
                        end else begin
                            m_mode = 3;
                        end
                    end
                end
                2: begin
                    m_rcnt++;
                    if (m_rcnt == 16) m_mode = 0;
                end
                default: if (!line_in) m_mode = 0;
            endcase
        end
        m_ready = (m_mode == 2);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison and ready pulse bookkeeping.
    int run = 0;
    int pulses = 0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(ready == m_ready, "R7 ready vs model", int'(ready), int'(m_ready));
            chk(data_out == m_data, "R5 data vs model", int'(data_out), int'(m_data));
            if (ready) begin
                run++;
            end else if (run != 0) begin
                chk(run == 16, "R7 ready length", run, 16);
                pulses++;
                run = 0;
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            finish_run();
        end
    end

    task automatic idle(input int n);
        line_in = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_bit(input logic v);
        line_in = v;
        repeat (16) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_hi);
        drive_bit(1'b1);
        for (int i = 0; i < 8; i++) drive_bit(b[i]);
        drive_bit(stop_hi);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(ready == 1'b0, "R1 ready in reset", int'(ready), 0);
        chk(data_out == 8'h00, "R1 data in reset", int'(data_out), 0);
        rst = 1'b0;
        idle(20);

        // Valid frame, asymmetric byte to expose bit order
        send_frame(8'h4B, 1'b0);
        idle(40);
        chk(data_out == 8'h4B, "R5 lsb-first byte", int'(data_out), 'h4B);
        chk(pulses == 1, "R7 one ready pulse", pulses, 1);

        // Short glitch
        line_in = 1'b1; repeat (5) @(negedge clk);
        idle(40);
        chk(pulses == 1, "R3 glitch rejected", pulses, 1);
        chk(data_out == 8'h4B, "R3 data kept after glitch", int'(data_out), 'h4B);

        // Start high for 10 clocks: rejected
        line_in = 1'b1; repeat (10) @(negedge clk);
        idle(40);
        chk(pulses == 1, "R2 ten-clock start rejected", pulses, 1);

        // Start high for 11 clocks: accepted, all-zero byte
        line_in = 1'b1; repeat (11) @(negedge clk);
        idle(200);
        chk(pulses == 2, "R2 eleven-clock start accepted", pulses, 2);
        chk(data_out == 8'h00, "R4 zero byte sampled mid-bit", int'(data_out), 0);

        // Bad stop bit, line held high through recovery
        send_frame(8'h3C, 1'b1);
        repeat (60) @(negedge clk);
        chk(pulses == 2, "R8 no ready on bad stop", pulses, 2);
        chk(data_out == 8'h00, "R8 data kept on bad stop", int'(data_out), 0);
        chk(ready == 1'b0, "R9 quiet in recovery", int'(ready), 0);
        idle(20);
        send_frame(8'h91, 1'b0);
        idle(40);
        chk(data_out == 8'h91, "R9 frame after recovery", int'(data_out), 'h91);
        chk(pulses == 3, "R9 ready after recovery", pulses, 3);

        // Line pulse inside the ready window
        send_frame(8'hE6, 1'b0);
        line_in = 1'b1; repeat (4) @(negedge clk);
        idle(60);
        chk(pulses == 4, "R10 blip during ready ignored", pulses, 4);
        chk(data_out == 8'hE6, "R10 data held", int'(data_out), 'hE6);

        // Frames one idle bit apart; stop bit stays out of the byte
        send_frame(8'h5C, 1'b0);
        chk(data_out == 8'h5C, "R6 first close frame", int'(data_out), 'h5C);
        idle(16);
        send_frame(8'h35, 1'b0);
        idle(40);
        chk(data_out == 8'h35, "R6 second close frame", int'(data_out), 'h35);
        chk(pulses == 6, "R7 two close pulses", pulses, 6);

        finish_run();
    end

endmodule